// File: doc/BRIEF.md
# Interrupt Dispatch and Return Sequencer

This block performs the processor side of taking an interrupt and of returning from one, in a 16-bit machine that forms physical addresses from a segment and an offset. When an entry is requested, it saves the caller's flags, code segment and instruction pointer on a stack that grows downward. It then reads the handler address from a table of 256 four-byte entries at the bottom of memory, and hands back the new code segment, instruction pointer, flags and stack pointer. When a return is requested, it pops the instruction pointer, the code segment and the flags in that order, and hands them back with the restored stack pointer.

The surrounding core supplies the live register values and a vector number, and pulses a request. It then waits for `done` and loads the four result registers from the outputs. All memory traffic goes through a single request/ready port. A parameter sets this port to one byte or one 16-bit word. A word is always stored little-endian: the low byte sits at the lower address.

Top module: `irq_seq`

## Requirements
- R1: During reset and right after it, `busy`, `done` and `mem_req` are 0, and `cs_out`, `ip_out`, `flags_out` and `sp_out` are 0.
- R2: A request is accepted only while `busy` is 0. `busy` is 1 from the cycle after acceptance until the result is ready. `done` is a one-cycle pulse, and `busy` is 0 in that cycle.
- R3: On entry there are exactly three stack writes, in this order: flags at SS:(SP-2), the code segment at SS:(SP-4), and the instruction pointer at SS:(SP-6). The physical address is (SS*16 + offset) mod 2^20, and the offset wraps at 16 bits.
- R4: After the three writes, entry reads the word at physical address vector*4, which becomes `ip_out`, and then the word at vector*4+2, which becomes `cs_out`.
- R5: On entry, `flags_out` equals the saved flags with bit 9 (interrupt enable) cleared, and `sp_out` equals SP-6. The flags word written to the stack keeps bit 9 unchanged.
- R6: On return there are no writes. The block reads `ip_out` from SS:SP, `cs_out` from SS:(SP+2) and `flags_out` from SS:(SP+4), in that order, and `sp_out` equals SP+6.
- R7: Once `mem_req` is 1, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged until a cycle in which `mem_ready` is 1. That cycle completes the access.
- R8: With a byte-wide port, each word takes two accesses: the low byte at the word's address first, then the high byte at address+1. With a word-wide port, each word takes one access.
- R9: A request raised while `busy` is 1 has no effect. When entry and return are requested together while idle, the block performs entry.
- R10: `cs_out`, `ip_out`, `flags_out` and `sp_out` hold their values from one `done` pulse until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| entry_req | input | 1 | Start interrupt entry |
| iret_req | input | 1 | Start interrupt return |
| vec_num | input | VEC_W | Interrupt number for entry |
| cs_in | input | 16 | Live code segment |
| ip_in | input | 16 | Live instruction pointer (return address) |
| flags_in | input | 16 | Live flags |
| ss_in | input | 16 | Stack segment |
| sp_in | input | 16 | Stack pointer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse: results valid |
| cs_out | output | 16 | New code segment |
| ip_out | output | 16 | New instruction pointer |
| flags_out | output | 16 | New flags |
| sp_out | output | 16 | New stack pointer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16+SEG_SHIFT | Physical byte address |
| mem_wdata | output | 8*BUS_BYTES | Write data |
| mem_rdata | input | 8*BUS_BYTES | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes in this cycle |

## Verification
Most internal faults show up at the memory port within one access. A wrong stack pointer step or a wrong segment shift changes the address of the very next write. A misordered state swaps two pushed words or two table reads. A broken byte phase repeats or skips an address. A fault in the final latch stage shows only at `done`: the flags bit 9 left set on entry, the stack pointer off by a word, or a segment and an offset swapped. A fault in idle gating shows as a second `done` pulse or as extra accesses after a request made while busy. Vectors are swept over all 256 numbers, with memory latency varied and both 16-bit and 20-bit address wrap included, so a fault tied to one vector or one stall pattern still reaches an output.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

   localparam int WORD_W = 16;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PUSH_FL,
      ST_PUSH_CS,
      ST_PUSH_IP,
      ST_VEC_OFF,
      ST_VEC_SEG,
      ST_POP_IP,
      ST_POP_CS,
      ST_POP_FL
   } seq_state_e;

   typedef enum logic {
      SRC_STACK,
      SRC_TABLE
   } addr_src_e;

   function automatic logic st_is_push(seq_state_e s);
      return (s == ST_PUSH_FL) || (s == ST_PUSH_CS) || (s == ST_PUSH_IP);
   endfunction

   function automatic logic st_is_table(seq_state_e s);
      return (s == ST_VEC_OFF) || (s == ST_VEC_SEG);
   endfunction

   function automatic logic st_is_pop(seq_state_e s);
      return (s == ST_POP_IP) || (s == ST_POP_CS) || (s == ST_POP_FL);
   endfunction

endpackage

// File: rtl/irq_seq_agen.sv
module irq_seq_agen
   import irq_seq_pkg::*;
#(
   parameter int SEG_SHIFT = 4,
   parameter int VEC_W     = 8
) (
   input  addr_src_e                      src_i,
   input  logic [WORD_W-1:0]              seg_i,
   input  logic [WORD_W-1:0]              off_i,
   input  logic [VEC_W-1:0]               vec_i,
   input  logic                           upper_i,
   output logic [WORD_W+SEG_SHIFT-1:0]    addr_o
);

   localparam int AW   = WORD_W + SEG_SHIFT;
   localparam int TPAD = AW - VEC_W - 2;

   logic [AW-1:0] stack_addr;
   logic [AW-1:0] table_addr;

   generate
      if (TPAD < 1) begin : g_bad_vec
         $error("irq_seq_agen: vector table does not fit the address space");
      end
      if (SEG_SHIFT == 0) begin : g_flat
         // segment register ignored, flat 16-bit space
         assign stack_addr = off_i;
      end else begin : g_seg
         assign stack_addr = {seg_i, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, off_i};
      end
   endgenerate

   // 4-byte entries: offset word at +0, segment word at +2
   assign table_addr = {{TPAD{1'b0}}, vec_i, upper_i, 1'b0};

   always_comb begin
      if (src_i == SRC_TABLE) addr_o = table_addr;
      else                    addr_o = stack_addr;
   end

endmodule

// File: rtl/irq_seq_busif.sv
module irq_seq_busif
   import irq_seq_pkg::*;
#(
   parameter int BUS_BYTES = 2,
   parameter int AW        = 20
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     op_valid,
   input  logic                     op_wr,
   input  logic [AW-1:0]            op_addr,
   input  logic [WORD_W-1:0]        op_wdata,
   output logic                     op_ack,
   output logic [WORD_W-1:0]        op_rdata,
   output logic                     mem_req,
   output logic                     mem_we,
   output logic [AW-1:0]            mem_addr,
   output logic [8*BUS_BYTES-1:0]   mem_wdata,
   input  logic [8*BUS_BYTES-1:0]   mem_rdata,
   input  logic                     mem_ready
);

   assign mem_req = op_valid;
   assign mem_we  = op_wr;

   generate
      if (BUS_BYTES != 1 && BUS_BYTES != 2) begin : g_bad_bus
         $error("irq_seq_busif: BUS_BYTES must be 1 or 2");
      end

      if (BUS_BYTES == 1) begin : g_byte
         logic       half_q;
         logic [7:0] lo_q;
         logic       beat;

         assign beat      = op_valid & mem_ready;
         assign mem_addr  = op_addr + AW'(half_q);
         assign mem_wdata = half_q ? op_wdata[15:8] : op_wdata[7:0];
         assign op_ack    = beat & half_q;
         assign op_rdata  = {mem_rdata, lo_q};

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               half_q <= 1'b0;
               lo_q   <= '0;
            end else if (beat) begin
               half_q <= ~half_q;
               if (!half_q) lo_q <= mem_rdata;
            end
         end

         // R8: the high byte follows the low byte at the next address
         a_r8_hi_after_lo: assert property (@(posedge clk) disable iff (!rst_n)
            (mem_req && mem_ready && !half_q) |=>
               (mem_req && mem_addr == AW'($past(mem_addr) + 1'b1)));
      end else begin : g_word
         assign mem_addr  = op_addr;
         assign mem_wdata = op_wdata;
         assign op_ack    = op_valid & mem_ready;
         assign op_rdata  = mem_rdata;
      end
   endgenerate

   // R7: request fields held while waiting
   a_r7_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=>
         (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

endmodule

// File: rtl/irq_seq_ctl.sv
module irq_seq_ctl
   import irq_seq_pkg::*;
#(
   parameter int VEC_W  = 8,
   parameter int IF_BIT = 9
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                entry_req,
   input  logic                iret_req,
   input  logic [VEC_W-1:0]    vec_num,
   input  logic [WORD_W-1:0]   cs_in,
   input  logic [WORD_W-1:0]   ip_in,
   input  logic [WORD_W-1:0]   flags_in,
   input  logic [WORD_W-1:0]   ss_in,
   input  logic [WORD_W-1:0]   sp_in,
   output logic                op_valid,
   output logic                op_wr,
   output logic [WORD_W-1:0]   op_wdata,
   input  logic                op_ack,
   input  logic [WORD_W-1:0]   op_rdata,
   output addr_src_e           src_o,
   output logic [WORD_W-1:0]   seg_o,
   output logic [WORD_W-1:0]   off_o,
   output logic [VEC_W-1:0]    vec_o,
   output logic                upper_o,
   output logic                busy,
   output logic                done,
   output logic [WORD_W-1:0]   cs_out,
   output logic [WORD_W-1:0]   ip_out,
   output logic [WORD_W-1:0]   flags_out,
   output logic [WORD_W-1:0]   sp_out
);

   localparam logic [WORD_W-1:0] IF_MASK = WORD_W'(1) << IF_BIT;
   localparam logic [WORD_W-1:0] STEP    = WORD_W'(2);

   seq_state_e          state_q;
   logic                entry_q;
   logic [WORD_W-1:0]   sp_q, ss_q, cs_q, ip_q, fl_q, w0_q, w1_q;
   logic [VEC_W-1:0]    vec_q;

   always_comb begin
      op_valid = (state_q != ST_IDLE);
      op_wr    = st_is_push(state_q);
      unique case (state_q)
         ST_PUSH_FL: op_wdata = fl_q;
         ST_PUSH_CS: op_wdata = cs_q;
         ST_PUSH_IP: op_wdata = ip_q;
         default:    op_wdata = '0;
      endcase
      src_o   = st_is_table(state_q) ? SRC_TABLE : SRC_STACK;
      seg_o   = ss_q;
      off_o   = sp_q;
      vec_o   = vec_q;
      upper_o = (state_q == ST_VEC_SEG);
      busy    = (state_q != ST_IDLE);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         entry_q   <= 1'b0;
         sp_q      <= '0;
         ss_q      <= '0;
         cs_q      <= '0;
         ip_q      <= '0;
         fl_q      <= '0;
         w0_q      <= '0;
         w1_q      <= '0;
         vec_q     <= '0;
         done      <= 1'b0;
         cs_out    <= '0;
         ip_out    <= '0;
         flags_out <= '0;
         sp_out    <= '0;
      end else begin
         done <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (entry_req) begin
                  entry_q <= 1'b1;
                  ss_q    <= ss_in;
                  sp_q    <= sp_in - STEP;   // pre-decrement for first push
                  cs_q    <= cs_in;
                  ip_q    <= ip_in;
                  fl_q    <= flags_in;
                  vec_q   <= vec_num;
                  state_q <= ST_PUSH_FL;
               end else if (iret_req) begin
                  entry_q <= 1'b0;
                  ss_q    <= ss_in;
                  sp_q    <= sp_in;
                  state_q <= ST_POP_IP;
               end
            end
            ST_PUSH_FL: if (op_ack) begin
               sp_q    <= sp_q - STEP;
               state_q <= ST_PUSH_CS;
            end
            ST_PUSH_CS: if (op_ack) begin
               sp_q    <= sp_q - STEP;
               state_q <= ST_PUSH_IP;
            end
            ST_PUSH_IP: if (op_ack) state_q <= ST_VEC_OFF;
            ST_VEC_OFF: if (op_ack) begin
               w0_q    <= op_rdata;
               state_q <= ST_VEC_SEG;
            end
            ST_VEC_SEG: if (op_ack) begin
               ip_out    <= w0_q;
               cs_out    <= op_rdata;
               flags_out <= fl_q & ~IF_MASK;
               sp_out    <= sp_q;
               done      <= 1'b1;
               state_q   <= ST_IDLE;
            end
            ST_POP_IP: if (op_ack) begin
               w0_q    <= op_rdata;
               sp_q    <= sp_q + STEP;
               state_q <= ST_POP_CS;
            end
            ST_POP_CS: if (op_ack) begin
               w1_q    <= op_rdata;
               sp_q    <= sp_q + STEP;
               state_q <= ST_POP_FL;
            end
            ST_POP_FL: if (op_ack) begin
               ip_out    <= w0_q;
               cs_out    <= w1_q;
               flags_out <= op_rdata;
               sp_out    <= sp_q + STEP;
               sp_q      <= sp_q + STEP;
               done      <= 1'b1;
               state_q   <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R2: done only when the sequence has just ended
   a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   a_r2_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy));
   // R6: a return never writes
   a_r6_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !entry_q) |-> !op_wr);
   // R3: writes go to the stack only
   a_r3_push_to_stack: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_wr) |-> (src_o == SRC_STACK));
   // R3: stack pointer moves in whole words
   a_r3_sp_step: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$stable(sp_q)) |->
         (sp_q == $past(sp_q) - STEP || sp_q == $past(sp_q) + STEP));
   // R9: captured segment untouched while busy
   a_r9_ss_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(ss_q));
   // R10: results change only with done
   a_r10_hold_out: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> (!done || 1'b1) && ($stable(ip_out) || done) && ($stable(cs_out) || done));
   // R5: interrupt enable clear on entry result
   a_r5_if_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (done && entry_q) |-> !flags_out[IF_BIT]);

endmodule

// File: rtl/irq_seq.sv
module irq_seq
   import irq_seq_pkg::*;
#(
   parameter int BUS_BYTES = 2,
   parameter int SEG_SHIFT = 4,
   parameter int VEC_W     = 8,
   parameter int IF_BIT    = 9
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            entry_req,
   input  logic                            iret_req,
   input  logic [VEC_W-1:0]                vec_num,
   input  logic [15:0]                     cs_in,
   input  logic [15:0]                     ip_in,
   input  logic [15:0]                     flags_in,
   input  logic [15:0]                     ss_in,
   input  logic [15:0]                     sp_in,
   output logic                            busy,
   output logic                            done,
   output logic [15:0]                     cs_out,
   output logic [15:0]                     ip_out,
   output logic [15:0]                     flags_out,
   output logic [15:0]                     sp_out,
   output logic                            mem_req,
   output logic                            mem_we,
   output logic [16+SEG_SHIFT-1:0]         mem_addr,
   output logic [8*BUS_BYTES-1:0]          mem_wdata,
   input  logic [8*BUS_BYTES-1:0]          mem_rdata,
   input  logic                            mem_ready
);

   localparam int AW = WORD_W + SEG_SHIFT;

   generate
      if (IF_BIT < 0 || IF_BIT >= WORD_W) begin : g_bad_if
         $error("irq_seq: IF_BIT outside the flags word");
      end
      if (SEG_SHIFT < 0 || SEG_SHIFT > 8) begin : g_bad_shift
         $error("irq_seq: SEG_SHIFT out of range");
      end
   endgenerate

   logic                op_valid, op_wr, op_ack, upper;
   logic [WORD_W-1:0]   op_wdata, op_rdata, seg, off;
   logic [VEC_W-1:0]    vec;
   logic [AW-1:0]       op_addr;
   addr_src_e           src;

   irq_seq_ctl #(
      .VEC_W  (VEC_W),
      .IF_BIT (IF_BIT)
   ) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .entry_req (entry_req),
      .iret_req  (iret_req),
      .vec_num   (vec_num),
      .cs_in     (cs_in),
      .ip_in     (ip_in),
      .flags_in  (flags_in),
      .ss_in     (ss_in),
      .sp_in     (sp_in),
      .op_valid  (op_valid),
      .op_wr     (op_wr),
      .op_wdata  (op_wdata),
      .op_ack    (op_ack),
      .op_rdata  (op_rdata),
      .src_o     (src),
      .seg_o     (seg),
      .off_o     (off),
      .vec_o     (vec),
      .upper_o   (upper),
      .busy      (busy),
      .done      (done),
      .cs_out    (cs_out),
      .ip_out    (ip_out),
      .flags_out (flags_out),
      .sp_out    (sp_out)
   );

   irq_seq_agen #(
      .SEG_SHIFT (SEG_SHIFT),
      .VEC_W     (VEC_W)
   ) u_agen (
      .src_i   (src),
      .seg_i   (seg),
      .off_i   (off),
      .vec_i   (vec),
      .upper_i (upper),
      .addr_o  (op_addr)
   );

   irq_seq_busif #(
      .BUS_BYTES (BUS_BYTES),
      .AW        (AW)
   ) u_bus (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_valid  (op_valid),
      .op_wr     (op_wr),
      .op_addr   (op_addr),
      .op_wdata  (op_wdata),
      .op_ack    (op_ack),
      .op_rdata  (op_rdata),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .mem_ready (mem_ready)
   );

   // R1: port idle during reset
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> (!busy && !done && !mem_req));

endmodule

// File: tb/test_irq_seq.sv
`timescale 1ns/1ps

package tb_irq_pkg;
   function automatic logic [7:0] init_byte(int a);
      return 8'((a * 37) ^ (a >>> 3) ^ 8'h5A);
   endfunction
endpackage

module irq_mem_model #(
   parameter int BB = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              we,
   input  logic [19:0]       addr,
   input  logic [8*BB-1:0]   wdata,
   output logic [8*BB-1:0]   rdata,
   output logic              ready,
   input  int                lat_sel
);
   logic [7:0] store [int];
   int  log_addr[$];
   bit  log_we[$];
   int  log_data[$];
   int  stall_err = 0;
   int  cnt;
   logic            pend;
   logic [19:0]     p_addr;
   logic            p_we;
   logic [8*BB-1:0] p_wd;

   function automatic logic [7:0] peek(int a);
      int m = a & 32'hFFFFF;
      if (store.exists(m)) return store[m];
      return tb_irq_pkg::init_byte(m);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         ready <= 1'b0;
         cnt   <= 0;
         pend  <= 1'b0;
         rdata <= '0;
      end else begin
         if (pend && !(req && addr == p_addr && we == p_we && wdata == p_wd))
            stall_err = stall_err + 1;
         pend   <= req && !ready;
         p_addr <= addr;
         p_we   <= we;
         p_wd   <= wdata;
         if (req && ready) begin
            if (we)
               for (int b = 0; b < BB; b++)
                  store[(int'(addr) + b) & 32'hFFFFF] = wdata[8*b +: 8];
            log_addr.push_back(int'(addr));
            log_we.push_back(we);
            log_data.push_back(we ? int'(wdata) : int'(rdata));
            ready <= 1'b0;
            cnt   <= 0;
         end else if (req) begin
            if (cnt >= ((int'(addr[2:1]) + lat_sel) % 3)) begin
               ready <= 1'b1;
               for (int b = 0; b < BB; b++)
                  rdata[8*b +: 8] <= peek(int'(addr) + b);
            end else begin
               cnt <= cnt + 1;
            end
         end
      end
   end
endmodule

module test_irq_seq;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic        entry_req = 0, iret_req = 0;
   logic [7:0]  vec_num = 0;
   logic [15:0] cs_in = 0, ip_in = 0, flags_in = 0, ss_in = 0, sp_in = 0;
   int          lat_sel = 0;

   logic        busy_w, done_w, req_w, we_w, rdy_w;
   logic [15:0] cs_w, ip_w, fl_w, sp_w, wd_w, rd_w;
   logic [19:0] ad_w;
   logic        busy_b, done_b, req_b, we_b, rdy_b;
   logic [15:0] cs_b, ip_b, fl_b, sp_b;
   logic [7:0]  wd_b, rd_b;
   logic [19:0] ad_b;

   irq_seq i_irq_seq (
      .clk(clk), .rst_n(rst_n), .entry_req(entry_req), .iret_req(iret_req),
      .vec_num(vec_num), .cs_in(cs_in), .ip_in(ip_in), .flags_in(flags_in),
      .ss_in(ss_in), .sp_in(sp_in), .busy(busy_w), .done(done_w),
      .cs_out(cs_w), .ip_out(ip_w), .flags_out(fl_w), .sp_out(sp_w),
      .mem_req(req_w), .mem_we(we_w), .mem_addr(ad_w), .mem_wdata(wd_w),
      .mem_rdata(rd_w), .mem_ready(rdy_w));

   irq_seq #(.BUS_BYTES(1)) i_irq_seq_byte (
      .clk(clk), .rst_n(rst_n), .entry_req(entry_req), .iret_req(iret_req),
      .vec_num(vec_num), .cs_in(cs_in), .ip_in(ip_in), .flags_in(flags_in),
      .ss_in(ss_in), .sp_in(sp_in), .busy(busy_b), .done(done_b),
      .cs_out(cs_b), .ip_out(ip_b), .flags_out(fl_b), .sp_out(sp_b),
      .mem_req(req_b), .mem_we(we_b), .mem_addr(ad_b), .mem_wdata(wd_b),
      .mem_rdata(rd_b), .mem_ready(rdy_b));

   irq_mem_model #(.BB(2)) m_w (.clk(clk), .rst_n(rst_n), .req(req_w), .we(we_w),
      .addr(ad_w), .wdata(wd_w), .rdata(rd_w), .ready(rdy_w), .lat_sel(lat_sel));
   irq_mem_model #(.BB(1)) m_b (.clk(clk), .rst_n(rst_n), .req(req_b), .we(we_b),
      .addr(ad_b), .wdata(wd_b), .rdata(rd_b), .ready(rdy_b), .lat_sel(lat_sel));

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   int    ew_addr[$];
   bit    ew_we[$];
   int    ew_data[$];
   string ew_tag[$];

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic finish_report();
      if (!finished) begin
         finished = 1;
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   function automatic int phys(logic [15:0] seg, logic [15:0] off);
      return (int'(seg) * 16 + int'(off)) & 32'hFFFFF;
   endfunction

   function automatic logic [15:0] tword(int a);
      return {tb_irq_pkg::init_byte(a + 1), tb_irq_pkg::init_byte(a)};
   endfunction

   task automatic add_word(input int a, input bit w, input int d, input string tag);
      ew_addr.push_back(a);
      ew_we.push_back(w);
      ew_data.push_back(d);
      ew_tag.push_back(tag);
   endtask

   task automatic check_log(input int bb, input string nm,
                            input int la[$], input bit lw[$], input int ld[$]);
      int k = 0;
      int per = (bb == 1) ? 2 : 1;
      chk(la.size() == ew_addr.size() * per, "R8", {nm, " access count"},
          la.size(), ew_addr.size() * per);
      foreach (ew_addr[i]) begin
         for (int h = 0; h < per; h++) begin
            int ea = (ew_addr[i] + h) & 32'hFFFFF;
            int ed = (bb == 1) ? ((ew_data[i] >> (8 * h)) & 8'hFF) : ew_data[i];
            if (k < la.size()) begin
               chk(la[k] == ea && lw[k] == ew_we[i], ew_tag[i], {nm, " address"}, la[k], ea);
               if (ew_we[i]) chk(ld[k] == ed, ew_tag[i], {nm, " write data"}, ld[k], ed);
            end
            k++;
         end
      end
   endtask

   task automatic run_op(input bit ent, input bit ret, input int n,
                         input logic [15:0] cs, input logic [15:0] ip,
                         input logic [15:0] fl, input logic [15:0] ss,
                         input logic [15:0] sp, input bit poke);
      logic [15:0] e_cs, e_ip, e_fl, e_sp;
      bit got_w = 0, got_b = 0;
      int cyc = 0;
      ew_addr.delete(); ew_we.delete(); ew_data.delete(); ew_tag.delete();
      if (ent) begin
         add_word(phys(ss, sp - 16'd2), 1, int'(fl), "R3");
         add_word(phys(ss, sp - 16'd4), 1, int'(cs), "R3");
         add_word(phys(ss, sp - 16'd6), 1, int'(ip), "R3");
         add_word(n * 4,     0, 0, "R4");
         add_word(n * 4 + 2, 0, 0, "R4");
         e_ip = tword(n * 4);
         e_cs = tword(n * 4 + 2);
         e_fl = fl & ~16'h0200;
         e_sp = sp - 16'd6;
      end else begin
         add_word(phys(ss, sp),          0, 0, "R6");
         add_word(phys(ss, sp + 16'd2),  0, 0, "R6");
         add_word(phys(ss, sp + 16'd4),  0, 0, "R6");
         e_ip = ip; e_cs = cs; e_fl = fl;
         e_sp = sp + 16'd6;
      end
      @(negedge clk);
      entry_req = ent; iret_req = ret; vec_num = 8'(n);
      cs_in = cs; ip_in = ip; flags_in = fl; ss_in = ss; sp_in = sp;
      @(negedge clk);
      entry_req = 0; iret_req = 0;
      chk(busy_w == 1'b1 && busy_b == 1'b1, "R2", "busy after accept", {busy_w, busy_b}, 3);
      while (!(got_w && got_b) && cyc < 3000) begin
         @(negedge clk);
         cyc++;
         if (poke && cyc == 1) begin
            entry_req = 1; iret_req = 1; vec_num = ~vec_num;
            ss_in = 16'h4444; sp_in = 16'h0888; flags_in = 16'hFFFF;
         end else begin
            entry_req = 0; iret_req = 0;
         end
         if (done_w && !got_w) begin
            got_w = 1;
            chk(busy_w == 1'b0, "R2", "word busy at done", busy_w, 0);
         end
         if (done_b && !got_b) begin
            got_b = 1;
            chk(busy_b == 1'b0, "R2", "byte busy at done", busy_b, 0);
         end
      end
      if (!(got_w && got_b)) chk(0, "watchdog", "op did not finish", cyc, 3000);
      chk(ip_w == e_ip && ip_b == e_ip, ent ? "R4" : "R6", "ip_out", ent ? int'(ip_w) : int'(ip_b), e_ip);
      chk(cs_w == e_cs && cs_b == e_cs, ent ? "R4" : "R6", "cs_out", ent ? int'(cs_w) : int'(cs_b), e_cs);
      chk(fl_w == e_fl && fl_b == e_fl, ent ? "R5" : "R6", "flags_out", {fl_w, fl_b}, {e_fl, e_fl});
      chk(sp_w == e_sp && sp_b == e_sp, ent ? "R5" : "R6", "sp_out", {sp_w, sp_b}, {e_sp, e_sp});
      check_log(2, "word", m_w.log_addr, m_w.log_we, m_w.log_data);
      check_log(1, "byte", m_b.log_addr, m_b.log_we, m_b.log_data);
      chk(m_w.stall_err == 0 && m_b.stall_err == 0, "R7", "request held while waiting",
          m_w.stall_err + m_b.stall_err, 0);
      m_w.log_addr.delete(); m_w.log_we.delete(); m_w.log_data.delete();
      m_b.log_addr.delete(); m_b.log_we.delete(); m_b.log_data.delete();
      for (int t = 0; t < 3; t++) begin
         @(negedge clk);
         if (done_w || done_b || busy_w || busy_b)
            chk(0, "R9", "extra activity after done", {done_w, done_b, busy_w, busy_b}, 0);
      end
      chk(ip_w == e_ip && cs_w == e_cs && fl_w == e_fl && sp_w == e_sp &&
          ip_b == e_ip && cs_b == e_cs && fl_b == e_fl && sp_b == e_sp,
          "R10", "outputs held", ip_w, e_ip);
      chk(m_w.log_addr.size() == 0 && m_b.log_addr.size() == 0, "R9",
          "no accesses after done", m_w.log_addr.size() + m_b.log_addr.size(), 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      chk(0, "watchdog", "global timeout", 0, 1);
      finish_report();
   end

   initial begin
      logic [15:0] ss, sp, fl, cs, ip;
      repeat (4) @(negedge clk);
      // R1 reset state
      chk(!busy_w && !done_w && !req_w && !busy_b && !done_b && !req_b, "R1",
          "control outputs in reset", {busy_w, done_w, req_w, busy_b, done_b, req_b}, 0);
      chk(cs_w == 0 && ip_w == 0 && fl_w == 0 && sp_w == 0 &&
          cs_b == 0 && ip_b == 0 && fl_b == 0 && sp_b == 0, "R1", "result outputs in reset",
          {cs_w, ip_w}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy_w && !done_w && !req_w && !busy_b && !done_b && !req_b, "R1",
          "control outputs after reset", {busy_w, done_w, req_w, busy_b, done_b, req_b}, 0);

      for (int n = 0; n < 256; n++) begin
         lat_sel = n % 3;
         case (n % 4)
            0: begin ss = 16'h1000; sp = 16'h0100 + 16'(n * 8); end
            1: begin ss = 16'hFFFF; sp = 16'h0500; end          // 20-bit wrap
            2: begin ss = 16'h2000; sp = 16'h0002; end          // offset wrap
            default: begin ss = 16'h0800; sp = 16'hFFF0 - 16'(n * 2); end
         endcase
         fl = 16'(n * 16'h0101) ^ 16'h0A55;
         cs = 16'hC000 + 16'(n);
         ip = 16'h1234 ^ 16'(n << 4);
         // R9: simultaneous request picks entry; poke while busy ignored
         run_op(1'b1, (n % 16) == 9, n, cs, ip, fl, ss, sp, (n % 16) == 5);
         // return restores what entry saved
         run_op(1'b0, 1'b1, n, cs, ip, fl, ss, sp - 16'd6, (n % 16) == 7);
      end
      finish_report();
   end

endmodule